// File: doc/BRIEF.md
# Link Synchronization Sequence Detector

This block watches the raw serial bit stream of several input lines during link bring-up. The bits have not yet been aligned to words. On each line it looks for three patterns. The first is a start-of-synchronization marker: a long run of zeros followed by a long run of ones. The second is a fixed 20-bit end-of-synchronization marker. The third is the K28.1 comma in either running-disparity form. Every pattern is found at any bit offset. The start marker is still accepted when clock-to-data skew makes either of its runs one bit longer or one bit shorter. None of the patterns can appear in a legal 8b/10b data stream.

Each line keeps a confidence count for each pattern. A per-line *live* flag rises after three hits of the same pattern with no hit of another pattern in between. The flag falls after 64 consumed bits with no hit, or when `clear` is pulsed. A sticky *seen* flag records that the live flag has risen at least once. Aggregate outputs report that every enabled line is live on the same pattern. Software uses these outputs while it scans clock phase and input delay, and uses the end-pattern aggregate to decide when to leave synchronization mode.

The input is a stream interface with one bit per line. A bit vector is consumed in every cycle where `in_valid` is high. `in_ready` is always high because the block never applies back-pressure. Cycles where `in_valid` is low change no detector state and no counter.

Top module: `sync_pattern_detector`

## Requirements
- R1: A run of ten 0s directly followed by ten 1s counts as one start-pattern hit. The hit is taken on the first 0 that ends the ones run.
- R2: A start-pattern hit also needs the zero run and the one run each to be 9, 10 or 11 bits long. A run of 8 or fewer, or of 12 or more, produces no hit.
- R3: The exact sequence 11001111110000001100 (oldest bit first) counts as one end-pattern hit at any bit offset. Any other 20-bit value does not.
- R4: Each of the 10-bit sequences 0011111001 and 1100000110 (oldest bit first) counts as one K28.1 hit at any bit offset.
- R5: A line's live flag for a pattern rises on the third hit of that pattern. A hit of a different pattern on the same line first resets the count to zero and drops that flag.
- R6: A live flag drops, and its count resets, once 64 consecutive consumed bits carry no hit of its pattern. It is still set after 63 such bits.
- R7: A seen flag is set together with its live flag. It stays set until `clear`, even after the live flag drops.
- R8: `clear` resets every live flag, seen flag, hit count and idle count by the next cycle. It takes priority over hits in the same cycle.
- R9: An aggregate output is 1 exactly when at least one line is enabled in `line_en` and every enabled line has that pattern's live flag set. Disabled lines are ignored.
- R10: `in_ready` is always 1. While `in_valid` is 0 the input bits are ignored, no flag changes and the idle count does not advance.
- R11: A stream of legal 8b/10b words, including both forms of K28.5, produces no hit of any pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bit vector on `in_bits` is valid this cycle |
| in_ready | output | 1 | Always 1; no back-pressure |
| in_bits | input | NUM_LINES | One new serial bit per line |
| line_en | input | NUM_LINES | Lines taking part in the aggregates |
| clear | input | 1 | Clears all live and seen flags and counts |
| sos_live | output | NUM_LINES | Per-line live start-pattern flag |
| eos_live | output | NUM_LINES | Per-line live end-pattern flag |
| k281_live | output | NUM_LINES | Per-line live K28.1 flag |
| sos_seen | output | NUM_LINES | Per-line sticky start-pattern flag |
| eos_seen | output | NUM_LINES | Per-line sticky end-pattern flag |
| k281_seen | output | NUM_LINES | Per-line sticky K28.1 flag |
| all_sos | output | 1 | All enabled lines live on the start pattern |
| all_eos | output | 1 | All enabled lines live on the end pattern |
| all_k281 | output | 1 | All enabled lines live on K28.1 |

## Verification
The start pattern is swept over every combination of zero-run and one-run lengths from 7 to 13. This separates the accepted window of one bit either side of ten from its near neighbours. The end pattern is placed after each of 20 lead-in lengths and again with single bits flipped, which tells an exact match from a near miss. K28.1 is placed after each of 10 offsets, in alternating and in single disparity forms. A stream of K28.5 and balanced data words shows that legal traffic never raises a flag. Further sequences cover the count reset caused by a different pattern, the 63/64-bit idle edge, cycles with `in_valid` low inside a word, and the aggregates under several `line_en` masks.

// File: rtl/sync_det_pkg.sv
package sync_det_pkg;

  localparam int PAT_NUM  = 3;
  localparam int PAT_SOS  = 0;
  localparam int PAT_EOS  = 1;
  localparam int PAT_K281 = 2;

  typedef logic [PAT_NUM-1:0] pat_vec_t;

  // Start marker run-length acceptance window
  localparam int SOS_RUN_MIN = 9;
  localparam int SOS_RUN_MAX = 11;
  localparam int SOS_CNT_W   = 4;

  // End marker, oldest bit in the MSB
  localparam int EOS_LEN = 20;
  localparam logic [EOS_LEN-1:0] EOS_WORD = 20'b1100_1111_1100_0000_1100;

  // Comma in both disparity forms, oldest bit in the MSB
  localparam int K_LEN = 10;
  localparam logic [K_LEN-1:0] K281_NEG = 10'b0011111001;
  localparam logic [K_LEN-1:0] K281_POS = 10'b1100000110;

endpackage

// File: rtl/sync_run_sos.sv
module sync_run_sos
  import sync_det_pkg::*;
#(
  parameter int RUN_MIN = SOS_RUN_MIN,
  parameter int RUN_MAX = SOS_RUN_MAX,
  parameter int CNT_W   = SOS_CNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic hit
);

  localparam logic [CNT_W-1:0] CNT_SAT = '1;
  localparam logic [CNT_W-1:0] LO      = CNT_W'(RUN_MIN);
  localparam logic [CNT_W-1:0] HI      = CNT_W'(RUN_MAX);

  logic             run_bit_q;
  logic [CNT_W-1:0] run_len_q;
  logic [CNT_W-1:0] prev_len_q;
  logic             run_ok, prev_ok;

  assign run_ok  = (run_len_q >= LO) && (run_len_q <= HI);
  assign prev_ok = (prev_len_q >= LO) && (prev_len_q <= HI);

  // A 0 that ends an in-window ones run preceded by an in-window zero run
  assign hit = bit_vld && !bit_in && run_bit_q && run_ok && prev_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_bit_q  <= 1'b0;
      run_len_q  <= '0;
      prev_len_q <= '0;
    end else if (bit_vld) begin
      if (bit_in == run_bit_q) begin
        if (run_len_q != CNT_SAT) run_len_q <= run_len_q + 1'b1;
      end else begin
        prev_len_q <= run_len_q;
        run_len_q  <= CNT_W'(1);
        run_bit_q  <= bit_in;
      end
    end
  end

  AST_SOS_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> ($stable(run_len_q) && $stable(run_bit_q))); // R10

endmodule

// File: rtl/sync_shift_match.sv
module sync_shift_match
  import sync_det_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic eos_hit,
  output logic k281_hit
);

  localparam int SH_W  = EOS_LEN;
  localparam int FILL_W = $clog2(SH_W + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(SH_W);

  logic [SH_W-2:0]   sh_q;
  logic [SH_W-1:0]   sh_nx;
  logic [FILL_W-1:0] fill_q;
  logic              eos_full, k_full;

  assign sh_nx    = {sh_q, bit_in};
  // Require real bits in the whole window, not reset zeros
  assign eos_full = fill_q >= FILL_W'(EOS_LEN - 1);
  assign k_full   = fill_q >= FILL_W'(K_LEN - 1);

  assign eos_hit  = bit_vld && eos_full && (sh_nx == EOS_WORD);
  assign k281_hit = bit_vld && k_full &&
                    ((sh_nx[K_LEN-1:0] == K281_NEG) || (sh_nx[K_LEN-1:0] == K281_POS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      fill_q <= '0;
    end else if (bit_vld) begin
      sh_q <= sh_nx[SH_W-2:0];
      if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
    end
  end

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(sh_q)); // R10

endmodule

// File: rtl/sync_hit_track.sv
module sync_hit_track #(
  parameter int HIT_TARGET = 3,
  parameter int QUIET_BITS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bit_vld,
  input  logic own_hit,
  input  logic other_hit,
  output logic live,
  output logic seen
);

  localparam int CW = $clog2(HIT_TARGET + 1);
  localparam int IW = $clog2(QUIET_BITS + 1);
  localparam logic [CW-1:0] TGT   = CW'(HIT_TARGET);
  localparam logic [CW-1:0] TGT_M = CW'(HIT_TARGET - 1);
  localparam logic [IW-1:0] QUIET = IW'(QUIET_BITS);

  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idle_q, idle_nx;
  logic          live_q, seen_q;

  assign idle_nx = (idle_q == QUIET) ? idle_q : idle_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q  <= '0;
      idle_q <= '0;
      live_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (bit_vld) begin
      if (own_hit) begin
        idle_q <= '0;
        if (cnt_q != TGT) cnt_q <= cnt_q + 1'b1;
        if (cnt_q >= TGT_M) begin
          live_q <= 1'b1;
          seen_q <= 1'b1;
        end
      end else begin
        idle_q <= idle_nx;
        if (other_hit || idle_nx == QUIET) begin
          cnt_q  <= '0;
          live_q <= 1'b0;
        end
      end
    end
  end

  assign live = live_q;
  assign seen = seen_q;

  AST_LIVE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live_q) |-> $past(own_hit && bit_vld)); // R5
  AST_LIVE_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(live_q) |-> $past(clear || (bit_vld && !own_hit))); // R6
  AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !clear) |=> seen_q); // R7
  AST_LIVE_HAS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> seen_q); // R7
  AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!live_q && !seen_q)); // R8

endmodule

// File: rtl/sync_line_det.sv
module sync_line_det
  import sync_det_pkg::*;
#(
  parameter int HIT_TARGET = 3,
  parameter int QUIET_BITS = 64
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clear,
  input  logic     bit_vld,
  input  logic     bit_in,
  output pat_vec_t live,
  output pat_vec_t seen
);

  pat_vec_t hits;

  sync_run_sos u_sos (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .hit     (hits[PAT_SOS])
  );

  sync_shift_match u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .eos_hit  (hits[PAT_EOS]),
    .k281_hit (hits[PAT_K281])
  );

  for (genvar p = 0; p < PAT_NUM; p++) begin : g_pat
    localparam pat_vec_t OWN_MASK = pat_vec_t'(1) << p;
    sync_hit_track #(
      .HIT_TARGET (HIT_TARGET),
      .QUIET_BITS (QUIET_BITS)
    ) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .bit_vld   (bit_vld),
      .own_hit   (hits[p]),
      .other_hit (|(hits & ~OWN_MASK)),
      .live      (live[p]),
      .seen      (seen[p])
    );
  end

  AST_PATTERNS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hits)); // R3
  AST_ONE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(live)); // R5

endmodule

// File: rtl/sync_pattern_detector.sv
module sync_pattern_detector
  import sync_det_pkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int HIT_TARGET = 3,
  parameter int QUIET_BITS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NUM_LINES-1:0] in_bits,
  input  logic [NUM_LINES-1:0] line_en,
  input  logic                 clear,
  output logic [NUM_LINES-1:0] sos_live,
  output logic [NUM_LINES-1:0] eos_live,
  output logic [NUM_LINES-1:0] k281_live,
  output logic [NUM_LINES-1:0] sos_seen,
  output logic [NUM_LINES-1:0] eos_seen,
  output logic [NUM_LINES-1:0] k281_seen,
  output logic                 all_sos,
  output logic                 all_eos,
  output logic                 all_k281
);

  pat_vec_t live_l [NUM_LINES];
  pat_vec_t seen_l [NUM_LINES];
  pat_vec_t agg;

  assign in_ready = 1'b1;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    sync_line_det #(
      .HIT_TARGET (HIT_TARGET),
      .QUIET_BITS (QUIET_BITS)
    ) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .bit_vld (in_valid),
      .bit_in  (in_bits[g]),
      .live    (live_l[g]),
      .seen    (seen_l[g])
    );
    assign sos_live[g]  = live_l[g][PAT_SOS];
    assign eos_live[g]  = live_l[g][PAT_EOS];
    assign k281_live[g] = live_l[g][PAT_K281];
    assign sos_seen[g]  = seen_l[g][PAT_SOS];
    assign eos_seen[g]  = seen_l[g][PAT_EOS];
    assign k281_seen[g] = seen_l[g][PAT_K281];
  end

  always_comb begin
    for (int p = 0; p < PAT_NUM; p++) begin
      agg[p] = |line_en;
      for (int i = 0; i < NUM_LINES; i++) begin
        if (line_en[i] && !live_l[i][p]) agg[p] = 1'b0;
      end
    end
  end

  assign all_sos  = agg[PAT_SOS];
  assign all_eos  = agg[PAT_EOS];
  assign all_k281 = agg[PAT_K281];

  AST_AGG_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (all_sos || all_eos || all_k281) |-> (line_en != '0)); // R9
  AST_AGG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({all_sos, all_eos, all_k281})); // R9

endmodule

// File: tb/sync_pattern_detector_bench.sv
module sync_pattern_detector_bench;

  localparam int NL = 4;
  localparam logic [19:0] EOS  = 20'b11001111110000001100;
  localparam logic [9:0]  KN   = 10'b0011111001;
  localparam logic [9:0]  KP   = 10'b1100000110;
  localparam logic [9:0]  K5N  = 10'b0011111010;
  localparam logic [9:0]  K5P  = 10'b1100000101;
  localparam logic [9:0]  D215 = 10'b1010101010;
  localparam logic [9:0]  D102 = 10'b0101010101;
  localparam logic [NL-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [NL-1:0] in_bits = '0;
  logic [NL-1:0] line_en = '1;
  logic clear = 1'b0;
  logic [NL-1:0] sos_live, eos_live, k281_live, sos_seen, eos_seen, k281_seen;
  logic all_sos, all_eos, all_k281;
  logic fill_b = 1'b0;
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sync_pattern_detector #(.NUM_LINES(NL)) u_sync_pattern_detector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .line_en(line_en), .clear(clear),
    .sos_live(sos_live), .eos_live(eos_live), .k281_live(k281_live),
    .sos_seen(sos_seen), .eos_seen(eos_seen), .k281_seen(k281_seen),
    .all_sos(all_sos), .all_eos(all_eos), .all_k281(all_k281)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic [NL-1:0] mask, input logic b);
    @(negedge clk);
    in_valid = 1'b1;
    for (int i = 0; i < NL; i++) in_bits[i] = mask[i] ? b : fill_b;
    fill_b = ~fill_b;
  endtask

  task automatic send_pat(input logic [NL-1:0] mask, input logic [63:0] pat, input int len);
    for (int i = len - 1; i >= 0; i--) send_bit(mask, pat[i]);
  endtask

  task automatic send_run(input logic [NL-1:0] mask, input logic b, input int n);
    for (int i = 0; i < n; i++) send_bit(mask, b);
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    in_valid = 1'b0;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check("R10 ready after reset", in_ready, 1);
    check("R8 live after reset", {sos_live, eos_live, k281_live}, 0);
    check("R8 seen after reset", {sos_seen, eos_seen, k281_seen}, 0);
    check("R9 aggregates after reset", {all_sos, all_eos, all_k281}, 0);

    // R1 / R2: start pattern run-length sweep
    for (int z = 7; z <= 13; z++) begin
      for (int o = 7; o <= 13; o++) begin
        logic ok;
        ok = (z >= 9 && z <= 11 && o >= 9 && o <= 11);
        do_clear();
        send_run(ALL, 1'b1, 2);
        for (int r = 0; r < 3; r++) begin
          send_run(ALL, 1'b0, z);
          send_run(ALL, 1'b1, o);
        end
        send_bit(ALL, 1'b0);
        settle();
        if (z == 10 && o == 10) check("R1 nominal start pattern", sos_live, ok ? ALL : '0);
        else check($sformatf("R2 start runs z=%0d o=%0d", z, o), sos_live, ok ? ALL : '0);
        check("R2 start aggregate", all_sos, ok);
      end
    end

    // R3: end pattern at every offset
    for (int off = 0; off < 20; off++) begin
      do_clear();
      send_run('0, 1'b0, off);
      for (int r = 0; r < 3; r++) send_pat(ALL, 64'(EOS), 20);
      settle();
      check($sformatf("R3 end pattern off=%0d", off), eos_live, ALL);
      check("R3 end pattern no comma", k281_live | sos_live, 0);
    end
    // R3: single-bit near misses
    for (int b = 0; b < 20; b += 3) begin
      do_clear();
      for (int r = 0; r < 3; r++) send_pat(ALL, 64'(EOS ^ (20'd1 << b)), 20);
      settle();
      check($sformatf("R3 near miss bit=%0d", b), eos_live, 0);
    end

    // R4: comma at every offset, alternating disparity
    for (int off = 0; off < 10; off++) begin
      do_clear();
      send_run('0, 1'b0, off);
      send_pat(ALL, {KN, KP, KN, KP}, 40);
      settle();
      check($sformatf("R4 comma off=%0d", off), k281_live, ALL);
      check("R4 comma no end", eos_live, 0);
    end
    do_clear();
    send_pat(ALL, {KN, KN, KN}, 30);
    settle();
    check("R4 negative form only", k281_live, ALL);
    do_clear();
    send_pat(ALL, {KP, KP, KP}, 30);
    settle();
    check("R4 positive form only", k281_live, ALL);

    // R5: two hits are not enough; another pattern resets the count
    do_clear();
    send_pat(ALL, {KN, KP}, 20);
    settle();
    check("R5 two hits not live", k281_live, 0);
    send_pat(ALL, 64'(EOS), 20);
    send_pat(ALL, {KN, KP}, 20);
    settle();
    check("R5 count reset by end pattern", k281_live, 0);
    send_pat(ALL, 64'(KN), 10);
    settle();
    check("R5 third hit after reset", k281_live, ALL);

    // R6 / R7: idle window edge
    send_run('0, 1'b0, 63);
    settle();
    check("R6 live after 63 idle bits", k281_live, ALL);
    send_run('0, 1'b0, 1);
    settle();
    check("R6 dropped after 64 idle bits", k281_live, 0);
    check("R7 seen held after drop", k281_seen, ALL);

    // R10: valid-low cycles inside words are ignored
    do_clear();
    for (int w = 0; w < 3; w++) begin
      for (int i = 9; i >= 0; i--) begin
        send_bit(ALL, KN[i]);
        @(negedge clk);
        in_valid = 1'b0;
        in_bits = ~in_bits;
      end
    end
    settle();
    check("R10 comma with gaps", k281_live, ALL);
    repeat (100) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_bits = ~in_bits;
    end
    check("R10 idle not advanced while invalid", k281_live, ALL);

    // R8: clear
    do_clear();
    check("R8 clear live", k281_live, 0);
    check("R8 clear seen", k281_seen, 0);

    // R11: legal 8b/10b traffic
    do_clear();
    for (int r = 0; r < 6; r++) send_pat(ALL, {K5N, K5P, D215, D102}, 40);
    settle();
    check("R11 data live", {sos_live, eos_live, k281_live}, 0);
    check("R11 data seen", {sos_seen, eos_seen, k281_seen}, 0);

    // R9: aggregates under enable masks
    do_clear();
    for (int r = 0; r < 3; r++) send_pat(4'b0111, 64'(EOS), 20);
    settle();
    check("R9 per-line end flags", eos_live, 4'b0111);
    line_en = 4'b0111; #1;
    check("R9 enabled subset live", all_eos, 1);
    line_en = 4'b1111; #1;
    check("R9 one enabled line not live", all_eos, 0);
    line_en = 4'b0001; #1;
    check("R9 single enabled line", all_eos, 1);
    line_en = 4'b0000; #1;
    check("R9 no enabled line", all_eos, 0);
    line_en = 4'b0111; #1;
    check("R9 other aggregates", {all_sos, all_k281}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule